// File: doc/BRIEF.md
# Digit-Serial Fixed Left Shifter

This block multiplies a digit-serial operand by a fixed power of two. Operands arrive as a stream of `DIGIT_W`-bit digits, least significant digit first, and leave as a stream of the same width whose value is the operand shifted left by `SHIFT` bit positions. The shift costs no adders. Each input bit lane is wired to a rotated output lane, and each lane passes through a short chain of delay flip-flops whose length depends on the lane index. The total number of delay flip-flops equals `SHIFT`. With a one-bit digit the structure is a single chain of `SHIFT` flops.

A second output, `tap_digit`, gives the same operand shifted by the smaller amount `TAP_SHIFT`. Its bits are read from intermediate stages of the same chains, so it adds no storage. A shared-shift network uses this output to feed another consumer from the same chains.

Both streams move together on one valid/ready handshake that is passed straight through the block. A digit is transferred in a cycle where `in_valid` and `out_ready` are both high and `word_start` is low. Back-pressure from `out_ready` reaches `in_ready` in the same cycle. While no digit is transferred, every stage holds its value. Pulsing `word_start` between words empties all chains, so the low-order positions of the next word fill with zeros.

Top module: `dsl_shift_net`

## Requirements
- R1: After reset, every delay stage is zero, so the first word behaves as if it were preceded by zero digits.
- R2: Digits are numbered k = 0, 1, ... in order of transfer since the last clear. Bit i of digit k has weight k*DIGIT_W+i. Operand X is formed from all transferred digits. The `out_digit` value shown during transfer k equals bits [k*DIGIT_W +: DIGIT_W] of X << SHIFT.
- R3: Under the same numbering, the `tap_digit` value shown during transfer k equals bits [k*DIGIT_W +: DIGIT_W] of X << TAP_SHIFT, where TAP_SHIFT <= SHIFT.
- R4: `in_ready` equals `out_ready` and `out_valid` equals `in_valid`, except in a cycle with `word_start` high, where both are low.
- R5: In a cycle with no transfer (`in_valid` low or `out_ready` low), no stage changes. A word sent with stalls and bubbles yields the same output digits as the same word sent back to back.
- R6: In a cycle with `word_start` high, no digit is transferred and all stages clear. The next word starts from an all-zero state, whatever the previous word held.
- R7: Input lane i feeds output lane (i+SHIFT) mod DIGIT_W through floor((i+SHIFT)/DIGIT_W) flops. On the cycle right after a clear, every output lane fed through at least one flop reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_start | input | 1 | Clears all chains; blocks transfer that cycle |
| in_valid | input | 1 | Input digit present |
| in_ready | output | 1 | Input digit accepted when high with in_valid |
| in_digit | input | DIGIT_W | Input digit, LSD first |
| out_valid | output | 1 | Output digits present |
| out_ready | input | 1 | Consumer accepts output digits |
| out_digit | output | DIGIT_W | Operand shifted by SHIFT |
| tap_digit | output | DIGIT_W | Operand shifted by TAP_SHIFT |

## Verification
Both outputs belong to the transfer in which they appear. Output lanes reached through zero flops follow `in_digit` in the same cycle. A source bit in lane i reaches its output floor((i+SHIFT)/DIGIT_W) transfers later. The bench therefore drives each digit just after a rising edge and reads the outputs at the following falling edge, before the transfer edge. It compares them with digit k of the shifted operand, which it works out from the word value. Stall and bubble cycles add edges without transfers, so the expected digit index advances only on transfers. The handshake outputs are read at the falling edge of each stall or clear cycle.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

  // Number of flops between source lane and output for a given shift.
  function automatic int lane_depth(input int lane, input int shift, input int dw);
    return (lane + shift) / dw;
  endfunction

  // Source lane that lands on destination lane dst after a rotation by shift.
  function automatic int src_lane(input int dst, input int shift, input int dw);
    return (((dst - (shift % dw)) % dw) + dw) % dw;
  endfunction

  // Longest chain any lane needs for a shift.
  function automatic int max_depth(input int shift, input int dw);
    return (shift + dw - 1) / dw;
  endfunction

endpackage

// File: rtl/dsl_lane_delay.sv
module dsl_lane_delay #(
  parameter int DEPTH = 1,
  parameter int TAPD  = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic adv,
  input  logic din,
  output logic main_q,
  output logic tap_q
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign main_q = din;
      assign tap_q  = din;
    end else begin : g_chain
      logic [DEPTH-1:0] stg;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg <= '0;
        end else if (clear) begin
          stg <= '0;
        end else if (adv) begin
          stg[0] <= din;
          for (int k = 1; k < DEPTH; k++) begin
            stg[k] <= stg[k-1];
          end
        end
      end

      assign main_q = stg[DEPTH-1];

      if (TAPD == 0) begin : g_tap_wire
        assign tap_q = din;
      end else begin : g_tap_stage
        assign tap_q = stg[TAPD-1];
      end
    end
  endgenerate

endmodule

// File: rtl/dsl_lane_rotate.sv
module dsl_lane_rotate #(
  parameter int DIGIT_W = 3,
  parameter int SHIFT   = 4
) (
  input  logic [DIGIT_W-1:0] din,
  output logic [DIGIT_W-1:0] dout
);

  generate
    for (genvar i = 0; i < DIGIT_W; i++) begin : g_lane
      assign dout[(i + SHIFT) % DIGIT_W] = din[i];
    end
  endgenerate

endmodule

// File: rtl/dsl_shift_net.sv
module dsl_shift_net #(
  parameter int DIGIT_W   = 3,
  parameter int SHIFT     = 4,
  parameter int TAP_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_start,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DIGIT_W-1:0] in_digit,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DIGIT_W-1:0] out_digit,
  output logic [DIGIT_W-1:0] tap_digit
);
  import dsl_pkg::*;

  localparam int MAXD = max_depth(SHIFT, DIGIT_W);

  logic               xfer;
  logic [DIGIT_W-1:0] main_lane;
  logic [DIGIT_W-1:0] tap_lane;

  assign in_ready  = out_ready & ~word_start;
  assign out_valid = in_valid & ~word_start;
  assign xfer      = in_valid & out_ready & ~word_start;

  generate
    for (genvar i = 0; i < DIGIT_W; i++) begin : g_lane
      localparam int D_MAIN = lane_depth(i, SHIFT, DIGIT_W);
      localparam int D_TAP  = lane_depth(i, TAP_SHIFT, DIGIT_W);

      dsl_lane_delay #(
        .DEPTH(D_MAIN),
        .TAPD (D_TAP)
      ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (word_start),
        .adv   (xfer),
        .din   (in_digit[i]),
        .main_q(main_lane[i]),
        .tap_q (tap_lane[i])
      );
    end
  endgenerate

  dsl_lane_rotate #(.DIGIT_W(DIGIT_W), .SHIFT(SHIFT)) u_rot_main (
    .din (main_lane),
    .dout(out_digit)
  );

  dsl_lane_rotate #(.DIGIT_W(DIGIT_W), .SHIFT(TAP_SHIFT)) u_rot_tap (
    .din (tap_lane),
    .dout(tap_digit)
  );

  if (MAXD < 0) begin : g_never
  end

endmodule

// File: rtl/dsl_shift_net_chk.sv
module dsl_shift_net_chk #(
  parameter int DIGIT_W   = 3,
  parameter int SHIFT     = 4,
  parameter int TAP_SHIFT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               word_start,
  input logic               in_valid,
  input logic               in_ready,
  input logic [DIGIT_W-1:0] in_digit,
  input logic               out_valid,
  input logic               out_ready,
  input logic [DIGIT_W-1:0] out_digit,
  input logic [DIGIT_W-1:0] tap_digit
);
  import dsl_pkg::*;

  function automatic logic [DIGIT_W-1:0] held_mask(input int s);
    logic [DIGIT_W-1:0] m;
    for (int j = 0; j < DIGIT_W; j++) begin
      m[j] = (lane_depth(src_lane(j, s, DIGIT_W), s, DIGIT_W) != 0);
    end
    return m;
  endfunction

  localparam logic [DIGIT_W-1:0] MAIN_MASK = held_mask(SHIFT);
  localparam logic [DIGIT_W-1:0] TAP_MASK  = held_mask(TAP_SHIFT);

  logic fresh;
  logic moved;

  assign moved = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fresh <= 1'b1;
    else        fresh <= 1'b0;
  end

  // R4, R6: a clear cycle blocks both handshake directions
  p_clear_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |-> (!in_ready && !out_valid));

  // R4: back-pressure reaches the producer in the same cycle
  p_backpressure_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready);

  // R5: no transfer means the stored state, and so the outputs for a steady input, hold
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!moved && !word_start) ##1 $stable(in_digit) |-> ($stable(out_digit) && $stable(tap_digit)));

  // R7: lanes fed through flops read zero right after a clear
  p_cleared_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |=> (((out_digit & MAIN_MASK) == '0) && ((tap_digit & TAP_MASK) == '0)));

  // R1: the first cycle after reset sees empty chains
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> (((out_digit & MAIN_MASK) == '0) && ((tap_digit & TAP_MASK) == '0)));

endmodule

bind dsl_shift_net dsl_shift_net_chk #(
  .DIGIT_W  (DIGIT_W),
  .SHIFT    (SHIFT),
  .TAP_SHIFT(TAP_SHIFT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .word_start(word_start),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_digit  (in_digit),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_digit (out_digit),
  .tap_digit (tap_digit)
);

// File: tb/dsl_shift_net_tb_top.sv
module dsl_shift_net_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW  = 3;
  localparam int SH  = 4;
  localparam int TSH = 2;
  localparam logic [DW-1:0] DMASK = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          word_start = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_digit = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_digit;
  logic [DW-1:0] tap_digit;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsl_shift_net #(.DIGIT_W(DW), .SHIFT(SH), .TAP_SHIFT(TSH)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_start(word_start),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_digit  (in_digit),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_digit (out_digit),
    .tap_digit (tap_digit)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: drive at posedge+1 (caller), sample at negedge, return at next posedge+1.
  task automatic step_cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic do_clear();
    word_start = 1'b1; in_valid = 1'b1; out_ready = 1'b1; in_digit = '1;
    @(negedge clk);
    check(!in_ready && !out_valid, "R6 clear blocks transfer", {in_ready, out_valid}, 0);
    step_cycle();
    word_start = 1'b0; in_valid = 1'b0;
  endtask

  // Send nd digits of val, checking both outputs per transfer (R2, R3).
  task automatic send_word(input logic [63:0] val, input int nd, input bit clear_first,
                           input int stall_every, input string tag);
    logic [63:0] sm, st;
    if (clear_first) do_clear();
    sm = val << SH;
    st = val << TSH;
    for (int k = 0; k < nd; k++) begin
      logic [DW-1:0] dg, em, et;
      dg = DW'(val >> (k*DW));
      em = DW'(sm >> (k*DW)) & DMASK;
      et = DW'(st >> (k*DW)) & DMASK;
      if (stall_every > 0 && (k % stall_every) == stall_every - 1) begin
        in_valid = 1'b1; out_ready = 1'b0; in_digit = ~dg;
        @(negedge clk);
        check(!in_ready && out_valid, "R4 R5 stall by out_ready", {in_ready, out_valid}, 1);
        step_cycle();
        in_valid = 1'b0; out_ready = 1'b1; in_digit = dg ^ 3'b101;
        @(negedge clk);
        check(in_ready && !out_valid, "R4 R5 bubble by in_valid", {in_ready, out_valid}, 2);
        step_cycle();
      end
      in_valid = 1'b1; out_ready = 1'b1; in_digit = dg;
      @(negedge clk);
      check(out_digit == em, {"R2 main digit ", tag}, out_digit, em);
      check(tap_digit == et, {"R3 tap digit ", tag}, tap_digit, et);
      step_cycle();
    end
    in_valid = 1'b0;
  endtask

  task automatic t_reset_first_word();
    // R1: no clear before the first word; empty chains must act as zero history
    send_word(64'hFFF, 4, 1'b0, 0, "R1 after reset");
  endtask

  task automatic t_basic_patterns();
    send_word(64'h9A5, 6, 1'b1, 0, "R2 mixed");
    send_word(64'h1, 5, 1'b1, 0, "R7 single one");
    send_word(64'h924, 6, 1'b1, 0, "R7 top lane");
    send_word(64'h5B_6D3, 9, 1'b1, 0, "R2 long");
  endtask

  task automatic t_backpressure();
    send_word(64'hC3_9A5, 9, 1'b1, 2, "R5 stalls");
  endtask

  task automatic t_clear_between_words();
    send_word(64'hFFFF, 6, 1'b1, 0, "R6 fill");
    send_word(64'h0, 5, 1'b1, 0, "R6 after clear");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid, "R4 idle handshake", {in_ready, out_valid}, 2);
    step_cycle();
    t_reset_first_word();
    t_basic_patterns();
    t_backpressure();
    t_clear_between_words();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule